// File: doc/BRIEF.md
# Multi-channel streaming word processor

This block sits in the data path of four independent transfer channels: an inbound data channel, an outbound data channel, an outbound command channel and an inbound event channel. Every 32-bit word that crosses a channel can be altered on its way through. The word can pass unchanged, have its two 16-bit halves exchanged, or be combined with a per-channel mask by AND, OR or XOR. Each channel also has its own accumulator. It can keep a running ones-complement checksum of the words it carries, so a message can be verified as it arrives or stamped as it leaves, without a second pass over memory.

Each channel is a valid/ready stream with one word of registered output. A word is taken when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the output register is empty or is being emptied in that same cycle, so back-pressure from `out_ready` travels straight back to the producer. A stalled channel keeps its output word and its accumulator frozen, and the other channels are not affected. Configuration goes through a plain write port that addresses one channel at a time. A clear strobe for each channel zeroes its accumulator. A combinational read port returns the checksum of a selected channel together with a verification-pass flag.

Top module: `xfer_word_engine`

## Requirements
- R1: After reset every `out_valid` bit is 0, every `in_ready` bit is 1, every accumulator reads 0, and each channel is set to pass words unchanged with its checksum disabled.
- R2: A word taken on a channel appears on that channel's `out_data`, with `out_valid` high, one clock edge after it is taken (operation code 0 = pass through unchanged; codes 5 to 7 also pass).
- R3: Operation code 1 exchanges the upper and lower 16-bit halves of the word.
- R4: Operation codes 2, 3 and 4 produce the bitwise AND, OR and XOR, respectively, of the word and the channel's mask.
- R5: While `out_valid` is high and `out_ready` is low on a channel, that channel holds `out_data` and `out_valid` unchanged, drives `in_ready` low, and leaves its accumulator unchanged.
- R6: With the checksum enabled, each taken word is added to the accumulator in 32-bit ones-complement arithmetic: the carry out of bit 31 is added back into bit 0.
- R7: Channels 0 and 3 (inbound) accumulate the word after the transform. Channels 1 and 2 (outbound) accumulate the word as it arrives, before the transform.
- R8: A `clr` pulse sets the channel's accumulator to 0. If a word is taken in the same cycle with the checksum enabled, the accumulator ends equal to that word's contribution alone.
- R9: `rd_sum` shows the accumulator of the channel selected by `rd_ch`. `rd_ok` is 1 exactly when that value is all ones.
- R10: A configuration write (`cfg_we`, with `cfg_ch` selecting the channel) applies to words taken in later cycles. A word taken in the same cycle as the write is processed with the previous setting.
- R11: Channels run concurrently and independently. Words taken on several channels in the same cycle are each processed with their own channel's setting, and traffic on one channel never changes another channel's output or accumulator.
- R12: With the checksum disabled, taken words leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W (2) | Channel addressed by the write |
| cfg_op | input | 3 | Operation code: 0 pass, 1 swap halves, 2 AND, 3 OR, 4 XOR |
| cfg_mask | input | W (32) | Mask for the AND/OR/XOR operations |
| cfg_sum_en | input | 1 | Checksum enable for the addressed channel |
| clr | input | NUM_CH (4) | Accumulator clear strobe, one bit per channel |
| in_valid | input | NUM_CH | Word offered, one bit per channel |
| in_ready | output | NUM_CH | Word can be taken, one bit per channel |
| in_data | input | NUM_CH*W | Input words, channel i in bits [i*W +: W] |
| out_valid | output | NUM_CH | Processed word present |
| out_ready | input | NUM_CH | Downstream accepts the word |
| out_data | output | NUM_CH*W | Processed words, channel i in bits [i*W +: W] |
| rd_ch | input | CH_W | Channel whose checksum is read |
| rd_sum | output | W | Accumulator of the selected channel |
| rd_ok | output | 1 | Selected accumulator equals all ones |

## Verification
Two events can land on the same accumulator edge: a clear strobe, and a word being taken with the checksum enabled. The bench provokes this by raising `clr` in the same cycle as `in_valid`, after the accumulator already holds a nonzero sum. The result must be exactly that word's contribution, with no trace of the earlier sum. The bench also drives a configuration write in the same cycle as a word is taken on that channel. It judges the result by the output word, which must still carry the old operation, while the next word must carry the new one.

// File: rtl/wp_pkg.sv
package wp_pkg;
  parameter int WORD_W = 32;

  typedef enum logic [2:0] {
    WOP_PASS = 3'd0,
    WOP_SWAP = 3'd1,
    WOP_AND  = 3'd2,
    WOP_OR   = 3'd3,
    WOP_XOR  = 3'd4
  } wop_e;
endpackage

// File: rtl/wp_xform.sv
module wp_xform
  import wp_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  wop_e         op,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int HALF = W / 2;

  always_comb begin
    case (op)
      WOP_SWAP: dout = {din[HALF-1:0], din[W-1:HALF]};
      WOP_AND:  dout = din & mask;
      WOP_OR:   dout = din | mask;
      WOP_XOR:  dout = din ^ mask;
      default:  dout = din;
    endcase
  end
endmodule

// File: rtl/wp_ocadd.sv
module wp_ocadd #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    // end-around carry; cannot overflow again because raw[W-1:0] <= 2^W-2 when carry is set
    sum = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end
endmodule

// File: rtl/wp_lane.sv
module wp_lane
  import wp_pkg::*;
#(
  parameter int W       = WORD_W,
  parameter bit INBOUND = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_op,
  input  logic [W-1:0] cfg_mask,
  input  logic         cfg_sum_en,
  input  logic         clr,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic [W-1:0] acc
);
  wop_e         op_q;
  logic [W-1:0] mask_q;
  logic         sum_en_q;
  logic [W-1:0] xformed;
  logic [W-1:0] sum_src;
  logic [W-1:0] sum_base;
  logic [W-1:0] sum_next;
  logic         ov_q;
  logic [W-1:0] od_q;
  logic [W-1:0] acc_q;
  logic         take;

  assign in_ready  = !ov_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign acc       = acc_q;

  wp_xform #(.W(W)) u_xform (
    .op   (op_q),
    .mask (mask_q),
    .din  (in_data),
    .dout (xformed)
  );

  generate
    if (INBOUND) begin : g_in
      assign sum_src = xformed;
    end else begin : g_out
      assign sum_src = in_data;
    end
  endgenerate

  assign sum_base = clr ? '0 : acc_q;

  wp_ocadd #(.W(W)) u_add (
    .a   (sum_base),
    .b   (sum_src),
    .sum (sum_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= WOP_PASS;
      mask_q   <= '0;
      sum_en_q <= 1'b0;
    end else if (cfg_we) begin
      op_q     <= wop_e'(cfg_op);
      mask_q   <= cfg_mask;
      sum_en_q <= cfg_sum_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else if (take) begin
      ov_q <= 1'b1;
      od_q <= xformed;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (take && sum_en_q) begin
      acc_q <= sum_next;
    end else if (clr) begin
      acc_q <= '0;
    end
  end
endmodule

// File: rtl/xfer_word_engine.sv
module xfer_word_engine
  import wp_pkg::*;
#(
  parameter int              NUM_CH      = 4,
  parameter int              W           = WORD_W,
  parameter logic [NUM_CH-1:0] INBOUND_MAP = 4'b1001,
  localparam int             CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CH_W-1:0]     cfg_ch,
  input  logic [2:0]          cfg_op,
  input  logic [W-1:0]        cfg_mask,
  input  logic                cfg_sum_en,
  input  logic [NUM_CH-1:0]   clr,
  input  logic [NUM_CH-1:0]   in_valid,
  output logic [NUM_CH-1:0]   in_ready,
  input  logic [NUM_CH*W-1:0] in_data,
  output logic [NUM_CH-1:0]   out_valid,
  input  logic [NUM_CH-1:0]   out_ready,
  output logic [NUM_CH*W-1:0] out_data,
  input  logic [CH_W-1:0]     rd_ch,
  output logic [W-1:0]        rd_sum,
  output logic                rd_ok
);
  logic [NUM_CH*W-1:0] acc_all;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      wp_lane #(.W(W), .INBOUND(INBOUND_MAP[i])) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we && (cfg_ch == CH_W'(i))),
        .cfg_op     (cfg_op),
        .cfg_mask   (cfg_mask),
        .cfg_sum_en (cfg_sum_en),
        .clr        (clr[i]),
        .in_valid   (in_valid[i]),
        .in_ready   (in_ready[i]),
        .in_data    (in_data[i*W +: W]),
        .out_valid  (out_valid[i]),
        .out_ready  (out_ready[i]),
        .out_data   (out_data[i*W +: W]),
        .acc        (acc_all[i*W +: W])
      );
    end
  endgenerate

  always_comb begin
    rd_sum = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (rd_ch == CH_W'(k)) rd_sum = acc_all[k*W +: W];
    end
  end

  assign rd_ok = &rd_sum;
endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
  parameter int NUM_CH = 4,
  parameter int W      = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   in_valid,
  input logic [NUM_CH-1:0]   in_ready,
  input logic [NUM_CH-1:0]   out_valid,
  input logic [NUM_CH-1:0]   out_ready,
  input logic [NUM_CH*W-1:0] out_data,
  input logic [NUM_CH-1:0]   clr,
  input logic [NUM_CH*W-1:0] acc_all
);
  // R1: first cycle out of reset has no pending output
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_valid == '0));

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R2: a taken word is presented on the next edge
      p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[i] && in_ready[i]) |=> out_valid[i]);

      // R5: stalled output keeps its word
      p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[i] && !out_ready[i]) |=> (out_valid[i] && $stable(out_data[i*W +: W])));

      // R5, R12: no take and no clear leaves the accumulator alone
      p_acc_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid[i] && in_ready[i]) && !clr[i]) |=> $stable(acc_all[i*W +: W]));

      // R8: a clear with no word taken yields zero
      p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !(in_valid[i] && in_ready[i])) |=> (acc_all[i*W +: W] == '0));
    end
  endgenerate
endmodule

bind xfer_word_engine wp_checker #(.NUM_CH(NUM_CH), .W(W)) u_wp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .clr       (clr),
  .acc_all   (acc_all)
);

// File: tb/xfer_word_engine_test.sv
`timescale 1ns/1ps
module xfer_word_engine_test;
  localparam int NCH = 4;
  localparam int DW  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_ch = '0;
  logic [2:0]      cfg_op = '0;
  logic [DW-1:0]   cfg_mask = '0;
  logic            cfg_sum_en = 1'b0;
  logic [NCH-1:0]  clr = '0;
  logic [NCH-1:0]  in_valid = '0;
  logic [NCH-1:0]  in_ready;
  logic [NCH*DW-1:0] in_data = '0;
  logic [NCH-1:0]  out_valid;
  logic [NCH-1:0]  out_ready = '1;
  logic [NCH*DW-1:0] out_data;
  logic [1:0]      rd_ch = '0;
  logic [DW-1:0]   rd_sum;
  logic            rd_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xfer_word_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_op(cfg_op),
    .cfg_mask(cfg_mask), .cfg_sum_en(cfg_sum_en), .clr(clr), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .rd_ch(rd_ch), .rd_sum(rd_sum), .rd_ok(rd_ok)
  );

  function automatic logic [31:0] oc_add(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[31:0] + {31'b0, t[32]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int ch, input logic [2:0] op, input logic [31:0] m, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_op = op; cfg_mask = m; cfg_sum_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_ch(input int ch);
    @(negedge clk);
    clr[ch] = 1'b1;
    @(negedge clk);
    clr[ch] = 1'b0;
  endtask

  task automatic read_sum(input int ch, output logic [31:0] s, output logic ok);
    rd_ch = 2'(ch);
    #0.5;
    s = rd_sum; ok = rd_ok;
  endtask

  // offer one word, check the registered output at the following negedge
  task automatic send(input int ch, input logic [31:0] d, input logic [31:0] exp, input string req);
    @(negedge clk);
    in_valid[ch] = 1'b1; in_data[ch*DW +: DW] = d;
    @(negedge clk);
    in_valid[ch] = 1'b0;
    chk(req, {31'b0, out_valid[ch]}, 32'd1);
    chk(req, out_data[ch*DW +: DW], exp);
  endtask

  task automatic t_reset;
    logic [31:0] s; logic ok;
    chk("R1 out_valid", {28'b0, out_valid}, 32'h0);
    chk("R1 in_ready", {28'b0, in_ready}, 32'hF);
    for (int c = 0; c < NCH; c++) begin
      read_sum(c, s, ok);
      chk("R1 sum", s, 32'h0);
    end
  endtask

  task automatic t_pass;
    logic [31:0] s; logic ok;
    send(0, 32'h1234_5678, 32'h1234_5678, "R2 pass default");
    read_sum(0, s, ok);
    chk("R12 sum held with checksum off", s, 32'h0);
    set_cfg(0, 3'd6, 32'hFFFF_0000, 1'b0);
    send(0, 32'hCAFE_0001, 32'hCAFE_0001, "R2 unused code passes");
  endtask

  task automatic t_swap;
    set_cfg(1, 3'd1, 32'h0, 1'b0);
    send(1, 32'hAABB_CCDD, 32'hCCDD_AABB, "R3 swap halves");
  endtask

  task automatic t_masks;
    set_cfg(2, 3'd2, 32'h0F0F_00FF, 1'b0);
    send(2, 32'h1234_5678, 32'h0204_0078, "R4 and");
    set_cfg(2, 3'd3, 32'h0F0F_00FF, 1'b0);
    send(2, 32'h1234_5678, 32'h1F3F_56FF, "R4 or");
    set_cfg(2, 3'd4, 32'h0F0F_00FF, 1'b0);
    send(2, 32'h1234_5678, 32'h1D3B_5687, "R4 xor");
  endtask

  task automatic t_carry;
    logic [31:0] s; logic ok;
    set_cfg(1, 3'd0, 32'h0, 1'b1);
    clear_ch(1);
    send(1, 32'hFFFF_0000, 32'hFFFF_0000, "R6 word a");
    send(1, 32'h0002_0001, 32'h0002_0001, "R6 word b");
    read_sum(1, s, ok);
    chk("R6 end-around carry", s, oc_add(32'hFFFF_0000, 32'h0002_0001));
    chk("R9 not all ones", {31'b0, ok}, 32'd0);
    clear_ch(1);
    send(1, 32'hF0F0_F0F0, 32'hF0F0_F0F0, "R9 word a");
    send(1, 32'h0F0F_0F0F, 32'h0F0F_0F0F, "R9 word b");
    read_sum(1, s, ok);
    chk("R9 sum all ones", s, 32'hFFFF_FFFF);
    chk("R9 ok flag", {31'b0, ok}, 32'd1);
    send(1, 32'h0000_0001, 32'h0000_0001, "R6 wrap word");
    read_sum(1, s, ok);
    chk("R6 all ones plus one", s, 32'h0000_0001);
  endtask

  task automatic t_side;
    logic [31:0] s; logic ok;
    set_cfg(0, 3'd4, 32'hFFFF_FFFF, 1'b1);
    clear_ch(0);
    send(0, 32'h0000_0001, 32'hFFFF_FFFE, "R7 inbound output");
    read_sum(0, s, ok);
    chk("R7 inbound sums transformed", s, 32'hFFFF_FFFE);
    set_cfg(1, 3'd4, 32'hFFFF_FFFF, 1'b1);
    clear_ch(1);
    send(1, 32'h0000_0001, 32'hFFFF_FFFE, "R7 outbound output");
    read_sum(1, s, ok);
    chk("R7 outbound sums raw", s, 32'h0000_0001);
  endtask

  task automatic t_backpressure;
    logic [31:0] s; logic ok;
    set_cfg(3, 3'd0, 32'h0, 1'b1);
    clear_ch(3);
    @(negedge clk);
    out_ready[3] = 1'b0;
    in_valid[3] = 1'b1; in_data[3*DW +: DW] = 32'h1111_2222;
    @(negedge clk);
    in_data[3*DW +: DW] = 32'h3333_4444;
    chk("R5 first word out", out_data[3*DW +: DW], 32'h1111_2222);
    chk("R5 in_ready low", {31'b0, in_ready[3]}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R5 word held", out_data[3*DW +: DW], 32'h1111_2222);
    chk("R5 valid held", {31'b0, out_valid[3]}, 32'd1);
    read_sum(3, s, ok);
    chk("R5 sum frozen", s, 32'h1111_2222);
    out_ready[3] = 1'b1;
    @(negedge clk);
    in_valid[3] = 1'b0;
    chk("R5 next word after release", out_data[3*DW +: DW], 32'h3333_4444);
    read_sum(3, s, ok);
    chk("R5 sum after release", s, oc_add(32'h1111_2222, 32'h3333_4444));
  endtask

  task automatic t_clear_collide;
    logic [31:0] s; logic ok;
    set_cfg(2, 3'd2, 32'h0000_FFFF, 1'b1);
    clear_ch(2);
    send(2, 32'h1234_5678, 32'h0000_5678, "R8 masked output");
    read_sum(2, s, ok);
    chk("R8 sum before clear", s, 32'h1234_5678);
    @(negedge clk);
    clr[2] = 1'b1; in_valid[2] = 1'b1; in_data[2*DW +: DW] = 32'h0000_0042;
    @(negedge clk);
    clr[2] = 1'b0; in_valid[2] = 1'b0;
    read_sum(2, s, ok);
    chk("R8 clear with word", s, 32'h0000_0042);
    clear_ch(2);
    read_sum(2, s, ok);
    chk("R8 clear alone", s, 32'h0);
  endtask

  task automatic t_cfg_timing;
    set_cfg(0, 3'd0, 32'h0, 1'b0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'd0; cfg_op = 3'd1; cfg_mask = '0; cfg_sum_en = 1'b0;
    in_valid[0] = 1'b1; in_data[0 +: DW] = 32'h0001_0002;
    @(negedge clk);
    cfg_we = 1'b0; in_valid[0] = 1'b0;
    chk("R10 old setting in write cycle", out_data[0 +: DW], 32'h0001_0002);
    send(0, 32'h0001_0002, 32'h0002_0001, "R10 new setting afterwards");
  endtask

  task automatic t_concurrent;
    logic [31:0] s1, s2; logic ok;
    set_cfg(0, 3'd1, 32'h0, 1'b0);
    set_cfg(1, 3'd2, 32'hFF00_FF00, 1'b0);
    set_cfg(2, 3'd3, 32'h0000_000F, 1'b1);
    set_cfg(3, 3'd4, 32'hFFFF_0000, 1'b0);
    clear_ch(2);
    read_sum(1, s1, ok);
    @(negedge clk);
    in_valid = '1;
    in_data = {32'h1234_5678, 32'hA0A0_A0A0, 32'h1234_5678, 32'h1234_5678};
    @(negedge clk);
    in_valid = '0;
    chk("R11 ch0 swap", out_data[0*DW +: DW], 32'h5678_1234);
    chk("R11 ch1 and", out_data[1*DW +: DW], 32'h1200_5600);
    chk("R11 ch2 or", out_data[2*DW +: DW], 32'hA0A0_A0AF);
    chk("R11 ch3 xor", out_data[3*DW +: DW], 32'hEDCB_5678);
    read_sum(2, s2, ok);
    chk("R11 ch2 sum", s2, 32'hA0A0_A0A0);
    send(0, 32'h5555_AAAA, 32'hAAAA_5555, "R11 ch0 alone");
    read_sum(2, s2, ok);
    chk("R11 ch2 sum untouched", s2, 32'hA0A0_A0A0);
    read_sum(1, s2, ok);
    chk("R11 ch1 sum untouched", s2, s1);
    chk("R11 others idle", {29'b0, out_valid[3:1]}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_swap();
    t_masks();
    t_carry();
    t_side();
    t_backpressure();
    t_clear_collide();
    t_cfg_timing();
    t_concurrent();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule